// File: doc/BRIEF.md
# Cipher Data Port Buffers

This block sits between a processor's data-in and data-out port registers and a 128-bit block cipher engine. On the input side, software writes 32-bit words one at a time. Four accepted writes fill one block, which is then offered to the engine through a valid/ready sink handshake. On the output side, the engine hands a finished block over through a valid/ready source handshake. Software then reads the block back as four 32-bit words, starting with word 0.

Neither side ever stalls the bus. Writing to a full input buffer drops the word and raises a sticky error flag. Reading from an empty output buffer returns zero and raises a separate sticky error flag. The input and output sides each have their own byte-order reversal control. All flags are gathered into one status word whose bit positions are fixed, because register-decode logic elsewhere reads them. A start pulse clears both error flags.

Top module: `cdp_top`

## Requirements
- R1: After reset, the status word reads 0x0001_0100. Input-empty is bit 8, input-full bit 9, input-error bit 10, output-empty bit 16, output-full bit 17 and output-error bit 18; all other bits are zero. After reset, `toEngValid` is low and `fromEngReady` is high.
- R2: Four accepted writes fill block words 0 to 3 in write order, with word 0 in bits 31:0 of `toEngData`. After the fourth write, input-full is set and `toEngValid` is high. Valid and data then stay unchanged until `toEngReady` is seen.
- R3: A write while input-full is set is dropped, leaving the offered block unchanged. The write sets input-error one cycle later, and input-error stays set.
- R4: A cycle with `toEngValid` and `toEngReady` both high empties the input buffer: the next cycle shows input-empty set and `toEngValid` low.
- R5: With `inSwapEn` high at the time of a write, word {b3,b2,b1,b0} is stored as {b0,b1,b2,b3}.
- R6: A block is accepted only while output-empty is set. Acceptance sets output-full. Each read returns the next word, in order 0 to 3, on `rdData` one cycle after `rdEn`. Output-full clears after the first read, and output-empty sets after the fourth.
- R7: From block acceptance until all four words are read, `fromEngReady` is low, so the engine stalls.
- R8: A read while output-empty is set returns zero one cycle later and sets output-error, which stays set.
- R9: With `outSwapEn` high at the time of a read, the word returned has its byte order reversed.
- R10: `startPulse` clears both error flags on the next cycle. An error event in the same cycle as the pulse leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Operation start, clears error flags |
| inSwapEn | input | 1 | Byte reversal on written words |
| outSwapEn | input | 1 | Byte reversal on read words |
| wrEn | input | 1 | Bus write to the data-in port |
| wrData | input | 32 | Written word |
| rdEn | input | 1 | Bus read of the data-out port |
| rdData | output | 32 | Read word, valid one cycle after rdEn |
| toEngValid | output | 1 | Input block offered to the engine |
| toEngData | output | 128 | Input block, word 0 in bits 31:0 |
| toEngReady | input | 1 | Engine takes the input block |
| fromEngValid | input | 1 | Engine offers a result block |
| fromEngData | input | 128 | Result block, word 0 in bits 31:0 |
| fromEngReady | output | 1 | Output buffer can take a block |
| statusWord | output | 32 | Buffer flags at fixed bit positions |

## Verification
Input blocks are built from distinct word values so that a lane mix-up shows at once. The same writes are repeated with swapping on, which separates byte reversal from word ordering. A write into a full buffer, made while the engine is held off, shows whether the word is dropped or overwrites the block. Output blocks are read back word by word with swapping off and then on. Extra reads of an empty buffer, and a start pulse that coincides with an error event, exercise the sticky-flag rules.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 4;
  localparam int LANE_W    = $clog2(BLK_WORDS);

  // control to datapath strobes
  typedef struct packed {
    logic              inWr;
    logic [LANE_W-1:0] inLane;
    logic              outLoad;
    logic              outRd;
    logic              outRdZero;
    logic [LANE_W-1:0] outRdLane;
  } cdp_strobe_t;

  function automatic logic [WORD_W-1:0] byteRev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W / 8; i++)
      r[8*i +: 8] = w[WORD_W - 8*(i+1) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cdp_ctrl.sv
module cdp_ctrl
  import cdp_pkg::*;
#(
  parameter int WORDS = BLK_WORDS
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        toEngReady,
  input  logic        fromEngValid,
  output logic        toEngValid,
  output logic        fromEngReady,
  output cdp_strobe_t strobes,
  output logic        inEmpty,
  output logic        inFull,
  output logic        inErr,
  output logic        outEmpty,
  output logic        outFull,
  output logic        outErr
);
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORDS);

  logic [CNT_W-1:0]  inCnt;
  logic [CNT_W-1:0]  outLeft;
  logic [LANE_W-1:0] outIdx;
  logic acceptWr, drainIn, loadOut, readOk;

  assign inEmpty  = (inCnt == '0);
  assign inFull   = (inCnt == FULL_CNT);
  assign outEmpty = (outLeft == '0);
  assign outFull  = (outLeft == FULL_CNT);

  assign acceptWr     = wrEn && !inFull;
  assign drainIn      = inFull && toEngReady;
  assign toEngValid   = inFull;
  assign fromEngReady = outEmpty;
  assign loadOut      = fromEngValid && outEmpty;
  assign readOk       = rdEn && !outEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt <= '0;
    end else if (drainIn) begin
      inCnt <= '0;
    end else if (acceptWr) begin
      inCnt <= inCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLeft <= '0;
      outIdx  <= '0;
    end else if (loadOut) begin
      outLeft <= FULL_CNT;
      outIdx  <= '0;
    end else if (readOk) begin
      outLeft <= outLeft - CNT_W'(1);
      outIdx  <= outIdx + LANE_W'(1);
    end
  end

  // sticky errors: start clears, a same-cycle event wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inErr  <= 1'b0;
      outErr <= 1'b0;
    end else begin
      inErr  <= (inErr  && !startPulse) || (wrEn && inFull);
      outErr <= (outErr && !startPulse) || (rdEn && outEmpty);
    end
  end

  always_comb begin
    strobes.inWr      = acceptWr;
    strobes.inLane    = inCnt[LANE_W-1:0];
    strobes.outLoad   = loadOut;
    strobes.outRd     = rdEn;
    strobes.outRdZero = outEmpty;
    strobes.outRdLane = outIdx;
  end

  a_r2_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    toEngValid && !toEngReady |=> toEngValid);
  a_r3_in_err: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && inFull |=> inErr);
  a_r4_drain: assert property (@(posedge clk) disable iff (!rstN)
    toEngValid && toEngReady |=> inEmpty && !toEngValid);
  a_r7_stall: assert property (@(posedge clk) disable iff (!rstN)
    fromEngValid && fromEngReady |=> outFull && !fromEngReady);
  a_r8_out_err: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && outEmpty |=> outErr);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && !(wrEn && inFull) |=> !inErr);
endmodule

// File: rtl/cdp_datapath.sv
module cdp_datapath
  import cdp_pkg::*;
#(
  parameter int WW    = WORD_W,
  parameter int WORDS = BLK_WORDS
) (
  input  logic                clk,
  input  logic                rstN,
  input  cdp_strobe_t         strobes,
  input  logic                inSwapEn,
  input  logic                outSwapEn,
  input  logic [WW-1:0]       wrData,
  input  logic [WW*WORDS-1:0] fromEngData,
  output logic [WW*WORDS-1:0] toEngData,
  output logic [WW-1:0]       rdData
);
  logic [WW-1:0] inWords  [WORDS];
  logic [WW-1:0] outWords [WORDS];
  logic [WW-1:0] wrWord;
  logic [WW-1:0] rdWord;

  assign wrWord = inSwapEn ? byteRev(wrData) : wrData;
  assign rdWord = outSwapEn ? byteRev(outWords[strobes.outRdLane])
                            : outWords[strobes.outRdLane];

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inWords[g]  <= '0;
        outWords[g] <= '0;
      end else begin
        if (strobes.inWr && strobes.inLane == LANE_W'(g))
          inWords[g] <= wrWord;
        if (strobes.outLoad)
          outWords[g] <= fromEngData[g*WW +: WW];
      end
    end
    assign toEngData[g*WW +: WW] = inWords[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.outRd) begin
      rdData <= strobes.outRdZero ? '0 : rdWord;
    end
  end

  a_r8_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.outRd && strobes.outRdZero |=> rdData == '0);
endmodule

// File: rtl/cdp_top.sv
module cdp_top
  import cdp_pkg::*;
#(
  parameter int WW    = WORD_W,
  parameter int WORDS = BLK_WORDS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic                inSwapEn,
  input  logic                outSwapEn,
  input  logic                wrEn,
  input  logic [WW-1:0]       wrData,
  input  logic                rdEn,
  output logic [WW-1:0]       rdData,
  output logic                toEngValid,
  output logic [WW*WORDS-1:0] toEngData,
  input  logic                toEngReady,
  input  logic                fromEngValid,
  input  logic [WW*WORDS-1:0] fromEngData,
  output logic                fromEngReady,
  output logic [31:0]         statusWord
);
  // bit positions read by the register decode
  localparam int IN_EMPTY_BIT  = 8;
  localparam int IN_FULL_BIT   = 9;
  localparam int IN_ERR_BIT    = 10;
  localparam int OUT_EMPTY_BIT = 16;
  localparam int OUT_FULL_BIT  = 17;
  localparam int OUT_ERR_BIT   = 18;

  cdp_strobe_t strobes;
  logic inEmpty, inFull, inErr, outEmpty, outFull, outErr;

  cdp_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .wrEn(wrEn), .rdEn(rdEn),
    .toEngReady(toEngReady), .fromEngValid(fromEngValid),
    .toEngValid(toEngValid), .fromEngReady(fromEngReady),
    .strobes(strobes),
    .inEmpty(inEmpty), .inFull(inFull), .inErr(inErr),
    .outEmpty(outEmpty), .outFull(outFull), .outErr(outErr)
  );

  cdp_datapath #(.WW(WW), .WORDS(WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inSwapEn(inSwapEn), .outSwapEn(outSwapEn),
    .wrData(wrData), .fromEngData(fromEngData),
    .toEngData(toEngData), .rdData(rdData)
  );

  always_comb begin
    statusWord = '0;
    statusWord[IN_EMPTY_BIT]  = inEmpty;
    statusWord[IN_FULL_BIT]   = inFull;
    statusWord[IN_ERR_BIT]    = inErr;
    statusWord[OUT_EMPTY_BIT] = outEmpty;
    statusWord[OUT_FULL_BIT]  = outFull;
    statusWord[OUT_ERR_BIT]   = outErr;
  end

  a_r2_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    toEngValid && !toEngReady |=> $stable(toEngData));
endmodule

// File: tb/tb_cdp_top.sv
`timescale 1ns/1ps
module tb_cdp_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startPulse = 0, inSwapEn = 0, outSwapEn = 0;
  logic         wrEn = 0, rdEn = 0, toEngReady = 0, fromEngValid = 0;
  logic [31:0]  wrData = '0;
  logic [127:0] fromEngData = '0;
  logic [31:0]  rdData, statusWord;
  logic [127:0] toEngData;
  logic         toEngValid, fromEngReady;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cdp_top dut (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd();
    @(negedge clk); rdEn = 1;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startPulse = 1;
    @(negedge clk); startPulse = 0;
  endtask

  task automatic drainIn();
    @(negedge clk); toEngReady = 1;
    @(negedge clk); toEngReady = 0;
  endtask

  task automatic loadOut(input logic [127:0] b);
    @(negedge clk); fromEngValid = 1; fromEngData = b;
    @(negedge clk); fromEngValid = 0;
  endtask

  task automatic t_reset();
    check("R1 status", statusWord, 128'h0001_0100);
    check("R1 valid/ready", {toEngValid, fromEngReady}, 2'b01);
  endtask

  task automatic t_assemble();
    wr(32'hA0A0_0001); wr(32'hB0B0_0002);
    check("R2 partial status", statusWord, 128'h0001_0000);
    wr(32'hC0C0_0003); wr(32'hD0D0_0004);
    check("R2 full status", statusWord, 128'h0001_0200);
    check("R2 valid", toEngValid, 1);
    check("R2 block", toEngData, 128'hD0D0_0004_C0C0_0003_B0B0_0002_A0A0_0001);
    repeat (3) @(negedge clk);
    check("R2 held", {toEngValid, toEngData}, {1'b1, 128'hD0D0_0004_C0C0_0003_B0B0_0002_A0A0_0001});
  endtask

  task automatic t_overflow();
    wr(32'hDEAD_BEEF);
    check("R3 block unchanged", toEngData, 128'hD0D0_0004_C0C0_0003_B0B0_0002_A0A0_0001);
    check("R3 in err", statusWord[10], 1);
    repeat (2) @(negedge clk);
    check("R3 sticky", statusWord[10], 1);
  endtask

  task automatic t_drain();
    drainIn();
    check("R4 empty", statusWord[9:8], 2'b01);
    check("R4 valid low", toEngValid, 0);
  endtask

  task automatic t_clear();
    pulseStart();
    check("R10 cleared", statusWord, 128'h0001_0100);
  endtask

  task automatic t_inswap();
    inSwapEn = 1;
    wr(32'h1122_3344); wr(32'h5566_7788); wr(32'h99AA_BBCC); wr(32'hDDEE_FF00);
    inSwapEn = 0;
    check("R5 swapped block", toEngData, 128'h00FF_EEDD_CCBB_AA99_8877_6655_4433_2211);
    drainIn();
  endtask

  task automatic t_output();
    logic [31:0] exp [4] = '{32'h0000_1111, 32'h2222_3333, 32'h4444_5555, 32'h6666_7777};
    loadOut({exp[3], exp[2], exp[1], exp[0]});
    check("R6 out full", statusWord[17:16], 2'b10);
    check("R7 ready low", fromEngReady, 0);
    @(negedge clk); fromEngValid = 1; fromEngData = '1;
    @(negedge clk); fromEngValid = 0;
    check("R7 still stalled", {fromEngReady, statusWord[17:16]}, 3'b010);
    for (int i = 0; i < 4; i++) begin
      rd();
      check("R6 word order", rdData, exp[i]);
      if (i == 0) check("R6 full clears", statusWord[17:16], 2'b00);
      if (i < 3) check("R7 ready low while partial", fromEngReady, 0);
    end
    check("R6 out empty", statusWord[17:16], 2'b01);
    check("R7 ready back", fromEngReady, 1);
  endtask

  task automatic t_underflow();
    rd();
    check("R8 zero", rdData, 0);
    check("R8 out err", statusWord[18], 1);
    rd();
    check("R8 sticky", statusWord[18], 1);
  endtask

  task automatic t_outswap();
    loadOut(128'h0D0E_0F10_090A_0B0C_0506_0708_0102_0304);
    outSwapEn = 1;
    rd(); check("R9 swap w0", rdData, 32'h0403_0201);
    rd(); check("R9 swap w1", rdData, 32'h0807_0605);
    outSwapEn = 0;
    rd(); check("R9 unswapped w2", rdData, 32'h090A_0B0C);
    rd();
  endtask

  task automatic t_start_vs_event();
    @(negedge clk); startPulse = 1; rdEn = 1;
    @(negedge clk); startPulse = 0; rdEn = 0;
    check("R10 event wins", statusWord[18], 1);
    pulseStart();
    check("R10 cleared again", statusWord[18], 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_assemble();
    t_overflow();
    t_drain();
    t_clear();
    t_inswap();
    t_output();
    t_underflow();
    t_clear();
    t_outswap();
    t_start_vs_event();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule